// File: doc/BRIEF.md
# Multicycle Single-Address Accumulator Processor

This block is a 16-bit processor with a single accumulator. Each instruction names at most one memory address. The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register, a temporary operand register, the accumulator and a small adder. A finite-state controller steps each instruction through fetch, decode, operand fetch, execute and write back. It drives one register transfer group per state.

The processor uses one single-port, word-addressed memory. The memory takes an address, write data and a write enable, and it returns read data one clock after it samples an address. An operand can be taken directly from the instruction. It can also be taken indirectly: the word at the instruction's address is read first and then used as the real address. The instruction set is load, add, store, jump and halt. Any other opcode does nothing.

Top module: `acc_cpu`

## Requirements
- R1: Instruction word layout: the opcode is in bits [15:12], bit [11] is 1 for indirect addressing and bits [10:0] hold the address. The opcodes are 0x0 halt, 0x1 load, 0x2 add, 0x3 store and 0x4 jump.
- R2: While `rst` is high at a clock edge, the program counter, all datapath registers and the accumulator are cleared and the controller returns to fetch. After such an edge, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0.
- R3: Execution begins at address 0, and the program counter advances by one on every fetch. The fetch of the second instruction presents address 1.
- R4: Load places the operand word in the accumulator. In direct mode the operand word is at the instruction's address. In indirect mode it is at the address held in that word.
- R5: Add places the 16-bit sum of the accumulator and the operand word in the accumulator. A carry out of bit 15 is dropped.
- R6: Store writes the accumulator to the effective address with exactly one single-cycle `mem_we` pulse. In indirect mode the effective address is the pointer read from the instruction's address.
- R7: Jump continues execution at the effective address, direct or indirect. The instruction that follows the jump is not executed.
- R8: An opcode of 0x5 to 0xF changes no state except the program counter and writes no memory.
- R9: Halt raises `halted` and holds it high until reset. While halted, no memory write occurs and `mem_addr` stays fixed.
- R10: Cycle counts: direct load or add take 10 cycles and direct store or jump take 7. Indirect mode adds 3 cycles. A no-op takes 5 cycles, and `halted` rises 5 cycles after a halt's fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory word address (from the address register) |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
A load-add-store-halt program is run from a table of operand pairs. The table covers all eight combinations of direct and indirect mode across the three memory instructions. In each program the pointer word differs from the data word, so a missing or doubled indirection stores the wrong value. The table includes sums that wrap past 16 bits, which exposes a widened or saturating adder. The cycle count until halt separates the direct path from the indirect path and catches a missing or extra wait state. Directed programs try direct and indirect jumps, an undefined opcode, a reset in the middle of a program and the idle halted state.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int W   = 16,
  parameter int OPW = 4,
  parameter int AW  = W - OPW - 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_we,
  output logic          halted
);
  localparam logic [OPW-1:0] OP_HALT  = 4'h0;
  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_STORE = 4'h3;
  localparam logic [OPW-1:0] OP_JUMP  = 4'h4;

  typedef enum logic [3:0] {
    S_FA, S_FW, S_FM, S_FI, S_DEC,
    S_PW, S_PM, S_PA,
    S_OW, S_OM, S_OT,
    S_EX, S_WB, S_HLT
  } state_t;

  state_t          st;
  logic [AW-1:0]   pc, mar;
  logic [W-1:0]    mbr, ir, tmp, acc, alu;

  logic [OPW-1:0]  op;
  logic            ind;
  logic            uses_data;

  assign op        = ir[W-1 -: OPW];
  assign ind       = ir[AW];
  assign uses_data = (op == OP_LOAD) || (op == OP_ADD);

  assign mem_addr  = mar;
  assign mem_wdata = acc;
  assign mem_we    = (st == S_WB) && (op == OP_STORE);
  assign halted    = (st == S_HLT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_FA;
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      tmp <= '0;
      acc <= '0;
      alu <= '0;
    end else begin
      case (st)
        S_FA: begin
          mar <= pc;
          st  <= S_FW;
        end
        S_FW: st <= S_FM;
        S_FM: begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
          st  <= S_FI;
        end
        S_FI: begin
          ir <= mbr;
          st <= S_DEC;
        end
        S_DEC: begin
          case (op)
            OP_HALT: st <= S_HLT;
            OP_LOAD, OP_ADD, OP_STORE, OP_JUMP: begin
              mar <= ir[AW-1:0];
              if (ind)            st <= S_PW;
              else if (uses_data) st <= S_OW;
              else                st <= S_EX;
            end
            default: st <= S_FA;
          endcase
        end
        S_PW: st <= S_PM;
        S_PM: begin
          mbr <= mem_rdata;
          st  <= S_PA;
        end
        S_PA: begin
          mar <= mbr[AW-1:0];
          st  <= uses_data ? S_OW : S_EX;
        end
        S_OW: st <= S_OM;
        S_OM: begin
          mbr <= mem_rdata;
          st  <= S_OT;
        end
        S_OT: begin
          tmp <= mbr;
          st  <= S_EX;
        end
        S_EX: begin
          alu <= (op == OP_ADD) ? acc + tmp : tmp;
          st  <= S_WB;
        end
        S_WB: begin
          if (uses_data)      acc <= alu;
          if (op == OP_JUMP)  pc  <= mar;
          st <= S_FA;
        end
        S_HLT: st <= S_HLT;
        default: st <= S_FA;
      endcase
    end
  end
endmodule

module acc_cpu_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted
);
  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0) && !mem_we && !halted);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R9
  halt_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> $stable(mem_addr));

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we), .halted(halted)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic        halted;

  int errors = 0;
  int checks = 0;
  int wecnt  = 0;

  logic [15:0] mem [0:2047];

  always #2 clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wecnt <= wecnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  // R1 encoding: op[15:12], indirect bit 11, address [10:0]
  function automatic logic [15:0] ins(input logic [3:0] op, input logic i, input int a);
    return {op, i, a[10:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 2048; k++) mem[k] = 16'h0000;
    mem[200] = 16'd300;
    mem[201] = 16'd301;
    mem[202] = 16'd302;
    mem[205] = 16'd4;
    mem[302] = 16'hDEAD;
    mem[303] = 16'hBEEF;
  endtask

  task automatic do_reset(input bit chk);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    if (chk) begin
      // R2
      check("R2 mem_addr after reset", 32'(mem_addr), 32'd0);
      check("R2 mem_we after reset", 32'(mem_we), 32'd0);
      check("R2 halted after reset", 32'(halted), 32'd0);
    end
    wecnt = 0;
    rst = 1'b0;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      #1;
    end
  endtask

  // {a, b, mode[2]=load ind, mode[1]=add ind, mode[0]=store ind, expected}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {16'h0005, 16'h0007, 3'b000, 16'h000C},
    {16'h1234, 16'h0F0F, 3'b100, 16'h2143},
    {16'hFFFF, 16'h0001, 3'b010, 16'h0000},
    {16'h8000, 16'h8000, 3'b001, 16'h0000},
    {16'h7FFF, 16'h0001, 3'b111, 16'h8000},
    {16'hABCD, 16'h0000, 3'b011, 16'hABCD},
    {16'h00FF, 16'hFF02, 3'b110, 16'h0001},
    {16'h4000, 16'h3FFF, 3'b101, 16'h7FFF}
  };

  task automatic load_basic(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m);
    clear_mem();
    mem[300] = a;
    mem[301] = b;
    mem[0] = ins(4'h1, m[2], m[2] ? 200 : 300);
    mem[1] = ins(4'h2, m[1], m[1] ? 201 : 301);
    mem[2] = ins(4'h3, m[0], m[0] ? 202 : 302);
    mem[3] = ins(4'h0, 1'b0, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, expc, w0;

    for (int v = 0; v < NV; v++) begin
      logic [15:0] a, b, e;
      logic [2:0] m;
      {a, b, m, e} = VEC[v];
      load_basic(a, b, m);
      do_reset(v == 0);
      run(cyc);
      expc = (10 + 3*m[2]) + (10 + 3*m[1]) + (7 + 3*m[0]) + 5;
      // R4 R5 R6
      check($sformatf("R4/R5/R6 stored sum vec %0d", v), 32'(mem[302]), 32'(e));
      // R10
      check($sformatf("R10 cycles to halt vec %0d", v), cyc, expc);
      // R6
      check($sformatf("R6 write count vec %0d", v), wecnt, 1);
    end

    // R3: second fetch address is 1, after the 10-cycle direct load
    load_basic(16'h0011, 16'h0022, 3'b000);
    do_reset(1'b0);
    @(negedge clk);
    check("R3 first fetch address", 32'(mem_addr), 32'd0);
    repeat (10) @(negedge clk);
    check("R3 second fetch address", 32'(mem_addr), 32'd1);

    // R2: reset mid-program restarts from address 0
    do_reset(1'b1);
    run(cyc);
    check("R2 restart after mid reset sum", 32'(mem[302]), 32'h0033);
    check("R2 restart after mid reset cycles", cyc, 32);

    // R9: halted holds, no writes, address frozen at halt fetch (3)
    w0 = wecnt;
    repeat (20) @(negedge clk);
    check("R9 halted held", 32'(halted), 32'd1);
    check("R9 no writes while halted", wecnt, w0);
    check("R9 address frozen", 32'(mem_addr), 32'd3);

    // R7: direct jump skips store at 2
    clear_mem();
    mem[300] = 16'h5A5A;
    mem[0] = ins(4'h1, 1'b0, 300);
    mem[1] = ins(4'h4, 1'b0, 4);
    mem[2] = ins(4'h3, 1'b0, 302);
    mem[3] = ins(4'h0, 1'b0, 0);
    mem[4] = ins(4'h3, 1'b0, 303);
    mem[5] = ins(4'h0, 1'b0, 0);
    do_reset(1'b0);
    run(cyc);
    check("R7 direct jump target executed", 32'(mem[303]), 32'h5A5A);
    check("R7 direct jump skipped store", 32'(mem[302]), 32'hDEAD);
    check("R7/R10 direct jump cycles", cyc, 29);

    // R7: indirect jump through pointer at 205 (holds 4)
    clear_mem();
    mem[300] = 16'h0C3C;
    mem[0] = ins(4'h1, 1'b0, 300);
    mem[1] = ins(4'h4, 1'b1, 205);
    mem[2] = ins(4'h3, 1'b0, 302);
    mem[3] = ins(4'h0, 1'b0, 0);
    mem[4] = ins(4'h3, 1'b0, 303);
    mem[5] = ins(4'h0, 1'b0, 0);
    do_reset(1'b0);
    run(cyc);
    check("R7 indirect jump target executed", 32'(mem[303]), 32'h0C3C);
    check("R7 indirect jump skipped store", 32'(mem[302]), 32'hDEAD);
    check("R7/R10 indirect jump cycles", cyc, 32);

    // R8: undefined opcodes leave accumulator and memory alone
    for (int op = 5; op < 16; op += 5) begin
      clear_mem();
      mem[300] = 16'h1357;
      mem[0] = ins(4'h1, 1'b0, 300);
      mem[1] = ins(4'(op), 1'b1, 200);
      mem[2] = ins(4'h3, 1'b0, 302);
      mem[3] = ins(4'h0, 1'b0, 0);
      do_reset(1'b0);
      run(cyc);
      check($sformatf("R8 opcode %0h accumulator kept", op), 32'(mem[302]), 32'h1357);
      check($sformatf("R8 opcode %0h single write", op), wecnt, 1);
      check($sformatf("R8/R10 opcode %0h cycles", op), cyc, 27);
      check($sformatf("R8 opcode %0h pointer untouched", op), 32'(mem[200]), 32'd300);
    end

    // R1/R10: halt at address 0 raises halted after 5 cycles
    clear_mem();
    mem[0] = ins(4'h0, 1'b1, 302);
    do_reset(1'b0);
    run(cyc);
    check("R1/R10 immediate halt cycles", cyc, 5);
    check("R9 immediate halt no write", wecnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule